// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures an incoming signal in one of two ways. In frequency mode it opens a gate lasting a programmable number of milliseconds, measured in time-base ticks, and counts rising edges of the chosen input while the gate is open. In period mode it waits for a rising edge of the low-frequency input. It then counts time-base ticks until the next rising edge, or until the second rising edge after that first one.

There are two inputs. The high-frequency input first goes through a divide-by-two stage, so its count is half the number of its rising edges. The low-frequency input is counted directly. The result register either clears when a measurement starts or keeps its value so that successive measurements add up. It saturates at all ones. Once the block is idle, the result can be shifted out serially, most significant bit first.

A controller sets the configuration inputs and pulses `start`. It then waits for `done` and reads `count_q` in parallel or through `ser_out` and `shift_en`. All inputs are expected to be synchronous to `clk` already.

Top module: `gated_meas_counter`

## Requirements
- R1: After reset, `count_q` is 0, and `busy`, `done` and `ser_out` are 0.
- R2: With `sel_hf`=0 and `lf_freq_mode`=1, each rising edge of `lf_in` seen while the gate is open adds 1 to the count.
- R3: With `sel_hf`=1, every second rising edge of `hf_in` after the start adds 1 to the count. The first counted edge is the second one, and `lf_freq_mode` has no effect.
- R4: In frequency mode, `gate_sel` values 0, 1, 2 and 3 give gates of 4, 8, 32 and 64 ms, where one ms is `TICKS_PER_MS` pulses of `ref_tick`. `busy` is high from the cycle after the start until the tick that completes the gate.
- R5: With `sel_hf`=0 and `lf_freq_mode`=0, the block waits for a first rising edge of `lf_in`. It then counts `ref_tick` pulses from the next cycle up to, but not including, the cycle of the closing edge. The closing edge is the next rising edge when `two_periods`=0 and the second following rising edge when `two_periods`=1.
- R6: A start with `accumulate`=0 clears the count. A start with `accumulate`=1 keeps it, so the new measurement adds to the previous result.
- R7: The count saturates at all ones and never wraps.
- R8: `done` rises when a measurement ends, stays high until the next accepted start, and clears on that start.
- R9: A `start` while `busy` is ignored and does not lengthen the gate. Input edges while idle leave the count unchanged.
- R10: While idle and not starting, `shift_en` shifts the count left by one and fills the low bit with 0. `ser_out` always shows the count's most significant bit. `shift_en` while `busy` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hf_in | input | 1 | High-frequency count input (halved before counting) |
| lf_in | input | 1 | Low-frequency count / period input |
| ref_tick | input | 1 | Time-base tick, one-cycle pulses |
| sel_hf | input | 1 | 1 selects hf_in, 0 selects lf_in |
| lf_freq_mode | input | 1 | With lf_in: 1 frequency mode, 0 period mode |
| gate_sel | input | 2 | Gate time select: 0=4, 1=8, 2=32, 3=64 ms |
| two_periods | input | 1 | Period mode spans two input periods when 1 |
| accumulate | input | 1 | Keep previous count at start when 1 |
| start | input | 1 | Start strobe |
| shift_en | input | 1 | Shift result left one bit |
| count_q | output | CNT_W | Result register |
| ser_out | output | 1 | Serial result, MSB of count_q |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Measurement finished |

## Verification
The bench builds the block with `CNT_W`=8 and `TICKS_PER_MS`=2. With a narrow result, saturation at 255 can be reached in a few hundred input edges. With few ticks per ms, even the 64 ms gate lasts only about a thousand clock cycles, so all four gate lengths can be timed tick by tick. Period mode is run with a tick on every cycle, so an input spacing of P cycles gives a count of P-1 for one period and 2P-1 for two periods.

// File: rtl/gmc_pkg.sv
package gmc_pkg;

    localparam int MAX_GATE_MS = 64;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATE   = 2'd1,
        ST_ARM    = 2'd2,
        ST_PERIOD = 2'd3
    } gmc_state_e;

    typedef struct packed {
        logic       use_hf;
        logic       freq_mode;
        logic [1:0] gate_sel;
        logic       two_per;
    } gmc_cfg_t;

    function automatic int gate_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4;
            2'd1:    return 8;
            2'd2:    return 32;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/gmc_rise_det.sv
module gmc_rise_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev_q;
    end
endmodule

// File: rtl/gmc_prescale.sv
module gmc_prescale (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic rise_in,
    output logic ev_out
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst || clr)   half_q <= 1'b0;
        else if (rise_in) half_q <= ~half_q;
    end

    assign ev_out = rise_in & half_q;

    // R3: between two counted events there must be a non-counted rise
    a_r3_halved: assert property (@(posedge clk) disable iff (rst)
        (ev_out && !clr) |=> !ev_out);
endmodule

// File: rtl/gmc_sequencer.sv
module gmc_sequencer
    import gmc_pkg::*;
#(
    parameter int TICKS_PER_MS = 1000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     accumulate,
    input  gmc_cfg_t cfg_in,
    input  logic     ref_tick,
    input  logic     hf_ev,
    input  logic     lf_rise,
    output logic     busy,
    output logic     done,
    output logic     accept,
    output logic     clear_cnt,
    output logic     inc_cnt
);
    localparam int GT_MAX = MAX_GATE_MS * TICKS_PER_MS;
    localparam int GT_W   = $clog2(GT_MAX);

    gmc_state_e        state_q;
    gmc_cfg_t          cfg_q;
    logic [GT_W-1:0]   gate_cnt_q;
    logic [GT_W-1:0]   gate_last;
    logic              per_seen_q;
    logic              done_q;
    logic              period_close;

    assign gate_last    = GT_W'(gate_ms(cfg_q.gate_sel) * TICKS_PER_MS - 1);
    assign period_close = !cfg_q.two_per || per_seen_q;
    assign accept       = (state_q == ST_IDLE) && start;
    assign clear_cnt    = accept && !accumulate;
    assign busy         = (state_q != ST_IDLE);
    assign done         = done_q;

    always_comb begin
        inc_cnt = 1'b0;
        case (state_q)
            ST_GATE:   inc_cnt = cfg_q.use_hf ? hf_ev : lf_rise;
            ST_PERIOD: inc_cnt = ref_tick && !(lf_rise && period_close);
            default:   inc_cnt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            gate_cnt_q <= '0;
            per_seen_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q      <= cfg_in;
                        gate_cnt_q <= '0;
                        per_seen_q <= 1'b0;
                        done_q     <= 1'b0;
                        state_q    <= (cfg_in.use_hf || cfg_in.freq_mode) ? ST_GATE : ST_ARM;
                    end
                end
                ST_GATE: begin
                    if (ref_tick) begin
                        if (gate_cnt_q == gate_last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            gate_cnt_q <= gate_cnt_q + 1'b1;
                        end
                    end
                end
                ST_ARM: begin
                    if (lf_rise) state_q <= ST_PERIOD;
                end
                ST_PERIOD: begin
                    if (lf_rise) begin
                        if (period_close) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            per_seen_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: done is never set while a measurement runs
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    // R8: done holds until a start arrives
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    // R4: gate counter stays within the selected gate
    a_r4_gate_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GATE) |-> (gate_cnt_q <= gate_last));
    // R9: a start while busy leaves the block busy or finishing normally
    a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !ref_tick && !lf_rise) |=> busy);
endmodule

// File: rtl/gmc_result.sv
module gmc_result #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic             shift,
    input  logic             busy,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_FULL = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
        end else if (shift) begin
            cnt_q <= {cnt_q[CNT_W-2:0], 1'b0};
        end
    end

    // R7: a full count stays full while only increments arrive
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_FULL && !clr && !shift) |=> (cnt_q == CNT_FULL));
    // R10: while busy the count only grows
    a_r10_busy_monotonic: assert property (@(posedge clk) disable iff (rst)
        busy |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/gated_meas_counter.sv
module gated_meas_counter
    import gmc_pkg::*;
#(
    parameter int CNT_W        = 20,
    parameter int TICKS_PER_MS = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hf_in,
    input  logic             lf_in,
    input  logic             ref_tick,
    input  logic             sel_hf,
    input  logic             lf_freq_mode,
    input  logic [1:0]       gate_sel,
    input  logic             two_periods,
    input  logic             accumulate,
    input  logic             start,
    input  logic             shift_en,
    output logic [CNT_W-1:0] count_q,
    output logic             ser_out,
    output logic             busy,
    output logic             done
);
    logic [1:0] rises;
    logic       hf_ev;
    logic       accept;
    logic       clear_cnt;
    logic       inc_cnt;
    logic       shift_ok;
    gmc_cfg_t   cfg_in;

    assign cfg_in = '{use_hf: sel_hf, freq_mode: lf_freq_mode,
                      gate_sel: gate_sel, two_per: two_periods};

    gmc_rise_det #(.W(2)) u_rise (
        .clk (clk),
        .rst (rst),
        .sig ({hf_in, lf_in}),
        .rise(rises)
    );

    gmc_prescale u_presc (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .rise_in(rises[1]),
        .ev_out (hf_ev)
    );

    gmc_sequencer #(.TICKS_PER_MS(TICKS_PER_MS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .accumulate(accumulate),
        .cfg_in    (cfg_in),
        .ref_tick  (ref_tick),
        .hf_ev     (hf_ev),
        .lf_rise   (rises[0]),
        .busy      (busy),
        .done      (done),
        .accept    (accept),
        .clear_cnt (clear_cnt),
        .inc_cnt   (inc_cnt)
    );

    assign shift_ok = shift_en && !busy && !start;

    gmc_result #(.CNT_W(CNT_W)) u_res (
        .clk  (clk),
        .rst  (rst),
        .clr  (clear_cnt),
        .inc  (inc_cnt),
        .shift(shift_ok),
        .busy (busy),
        .cnt_q(count_q)
    );

    assign ser_out = count_q[CNT_W-1];

    // R6: an accepted start without accumulate leaves a zero count
    a_r6_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !accumulate) |=> (count_q == '0));
    // R9: idle count only changes through start or shift
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !shift_en) |=> $stable(count_q));
endmodule

// File: tb/tb_gated_meas_counter.sv
module tb_gated_meas_counter;
    localparam int CNT_W = 8;
    localparam int TPM   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hf_in = 0, lf_in = 0, ref_tick = 0;
    logic sel_hf = 0, lf_freq_mode = 0, two_periods = 0, accumulate = 0;
    logic start = 0, shift_en = 0;
    logic [1:0] gate_sel = 0;
    logic [CNT_W-1:0] count_q;
    logic ser_out, busy, done;

    int checks = 0, errors = 0;
    int tick_per = 8;
    int tk = 0;
    int gticks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    gated_meas_counter #(.CNT_W(CNT_W), .TICKS_PER_MS(TPM)) dut (
        .clk(clk), .rst(rst), .hf_in(hf_in), .lf_in(lf_in), .ref_tick(ref_tick),
        .sel_hf(sel_hf), .lf_freq_mode(lf_freq_mode), .gate_sel(gate_sel),
        .two_periods(two_periods), .accumulate(accumulate), .start(start),
        .shift_en(shift_en), .count_q(count_q), .ser_out(ser_out),
        .busy(busy), .done(done)
    );

    always @(negedge clk) begin
        tk = (tk + 1 >= tick_per) ? 0 : tk + 1;
        ref_tick = (tk == 0);
    end

    always @(posedge clk) begin
        if (start && !busy) gticks <= 0;
        else if (busy && ref_tick) gticks <= gticks + 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        int hf; int gsel; int edges; int acc; int exp_cnt;
    } vec_t;
    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{0, 0, 10, 0, 10},
        '{1, 1,  6, 0,  3},
        '{1, 2,  7, 0,  3},
        '{0, 3, 20, 1, 23},
        '{0, 0,  5, 0,  5}
    };

    function automatic int exp_ms(int sel);
        case (sel)
            0: return 4;
            1: return 8;
            2: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic do_start(int hf, int fm, int gs, int two, int acc);
        @(negedge clk);
        sel_hf = hf[0]; lf_freq_mode = fm[0]; gate_sel = gs[1:0];
        two_periods = two[0]; accumulate = acc[0]; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic pulse_lf(int n, int spacing);
        for (int i = 0; i < n; i++) begin
            lf_in = 1;
            @(negedge clk);
            lf_in = 0;
            repeat (spacing - 1) @(negedge clk);
        end
    endtask

    task automatic pulse_hf(int n, int spacing);
        for (int i = 0; i < n; i++) begin
            hf_in = 1;
            @(negedge clk);
            hf_in = 0;
            repeat (spacing - 1) @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 count", count_q, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 ser_out", ser_out, 0);

        // frequency-mode table: R2 R3 R4 R6 R9
        tick_per = 8;
        for (int v = 0; v < NV; v++) begin
            do_start(VECS[v].hf, VECS[v].hf ? 0 : 1, VECS[v].gsel, 0, VECS[v].acc);
            chk("R8 done cleared by start", done, 0);
            @(negedge clk);
            if (VECS[v].hf != 0) pulse_hf(VECS[v].edges, 2);
            else                 pulse_lf(VECS[v].edges, 2);
            start = 1;
            @(negedge clk);
            start = 0;
            wait_idle();
            chk(VECS[v].hf ? "R3 hf halved count" : "R2 lf count / R6", count_q, VECS[v].exp_cnt);
            chk("R4 gate ticks / R9 start ignored", gticks, exp_ms(VECS[v].gsel) * TPM);
            chk("R8 done at end", done, 1);
            if (v == 0) begin
                pulse_lf(3, 2);
                pulse_hf(4, 2);
                chk("R9 idle edges ignored", count_q, 10);
            end
        end

        // period mode, R5
        tick_per = 1;
        do_start(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        pulse_lf(2, 10);
        wait_idle();
        chk("R5 one period", count_q, 9);
        do_start(0, 0, 0, 1, 0);
        repeat (3) @(negedge clk);
        pulse_lf(2, 7);
        chk("R5 still busy after two edges", busy, 1);
        pulse_lf(1, 1);
        @(negedge clk);
        wait_idle();
        chk("R5 two periods", count_q, 13);

        // saturation, R7
        tick_per = 8;
        do_start(0, 1, 3, 0, 0);
        pulse_lf(300, 2);
        wait_idle();
        chk("R7 saturate", count_q, 255);
        repeat (20) @(negedge clk);
        chk("R8 done holds", done, 1);

        // shift out, R10
        do_start(0, 1, 3, 0, 0);
        pulse_lf(165, 2);
        wait_idle();
        chk("R10 preload", count_q, 165);
        for (int b = 0; b < CNT_W; b++) begin
            chk("R10 ser_out bit", ser_out, (165 >> (CNT_W - 1 - b)) & 1);
            shift_en = 1;
            @(negedge clk);
            shift_en = 0;
        end
        chk("R10 emptied", count_q, 0);

        do_start(0, 1, 0, 0, 0);
        pulse_lf(4, 2);
        shift_en = 1;
        repeat (2) @(negedge clk);
        shift_en = 0;
        wait_idle();
        chk("R10 shift ignored while busy", count_q, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule